// File: doc/BRIEF.md
# EEPROM Page Write Cycle Controller

This block sits behind the serial slave engine of a byte-wide EEPROM. While a write command is in flight it gathers the data bytes into a page-sized buffer. A column counter places the bytes and wraps inside the page, so that the fixed upper address bits never change. When the engine reports a STOP that closes a complete data byte, the block starts a timed internal write cycle. During that cycle it raises `busy` and drains the filled buffer slots into the memory array through a write port. The cycle lasts a fixed number of system clocks for the whole page, not a fixed time per byte.

A write-protect input guards the cycle. WP is ignored until the engine marks the clock edge that samples the first data bit (D0) of the first data byte. From that edge onward, WP high throws away the pending command. If WP goes high while the cycle runs, the cycle is cut short and the block returns to standby at once. It then reports a done pulse flagged as aborted, and the byte that was being written is not guaranteed.

Both data paths are valid/ready streams. Incoming bytes are taken on `byte_valid && byte_ready`. `byte_ready` is low for the whole internal cycle, and a source must hold its byte until it is taken. The memory port presents `mem_wr_valid` with a stable address and data until `mem_wr_ready`. An abort is the one exception: it withdraws the request. While the memory stalls, the cycle is stretched until every filled slot has been written.

Top module: `page_write_ctrl`

## Requirements
- R1: The column counter takes the low log2(PAGE_BYTES) bits of the loaded address and increments with wrap inside the page. For 8-byte pages, a start at 06h writes 06h, 07h, 00h, 01h. Every memory write keeps the upper address bits that were loaded.
- R2: When more than PAGE_BYTES data bytes arrive, later bytes replace earlier ones at the same column, and the last byte sent to each column is the one committed.
- R3: Only columns that received a byte are written, each once per cycle, at address {upper bits, column}. Columns that received no byte keep their old memory contents.
- R4: A STOP while `bit_pending` is high (partial byte), or a STOP after a command with no data byte, starts no cycle: `busy` stays low and no memory write occurs.
- R5: With the memory always ready, `busy` rises in the cycle after an accepted STOP and stays high for exactly WR_CYCLES clock cycles. `cycle_done` pulses for one cycle as `busy` falls, with `cycle_aborted` low.
- R6: WP high in the cycle of `d0_edge`, or at any time after it and before STOP, cancels the command: the STOP starts no cycle and nothing is written.
- R7: WP high between `cmd_start` and `d0_edge` has no effect; the write completes normally.
- R8: WP high during the cycle ends it at the next clock edge: `busy` falls, and `cycle_done` and `cycle_aborted` pulse together. No memory write occurs after that.
- R9: While `busy` is high, `byte_ready` is low and offered bytes change nothing in the committed data.
- R10: While `mem_wr_valid` is high and `mem_wr_ready` low, the address and data hold stable. `busy` stays high past WR_CYCLES until all filled columns are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Pulse: START of a new command, clears the buffer |
| addr_set | input | 1 | Pulse: word address received |
| addr_in | input | ADDR_W | Word address of the first data byte |
| d0_edge | input | 1 | Pulse: clock edge sampling D0 of the first data byte |
| byte_valid | input | 1 | Data byte offered |
| byte_ready | output | 1 | Block accepts a data byte (low while busy) |
| byte_data | input | 8 | Data byte |
| bit_pending | input | 1 | A partial byte has been shifted in at STOP time |
| stop_evt | input | 1 | Pulse: STOP condition seen |
| wp | input | 1 | Write-protect level |
| busy | output | 1 | Internal write cycle in progress |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_addr | output | ADDR_W | Memory write address |
| mem_wr_data | output | 8 | Memory write data |
| cycle_done | output | 1 | One-cycle pulse at the end of a cycle |
| cycle_aborted | output | 1 | With cycle_done: cycle was cut short by WP |

## Verification
All results are registered. `busy` is due at the first falling edge after the rising edge that accepts STOP. `cycle_done` and `cycle_aborted` appear at the same falling edge where `busy` is first seen low. After WP rises during a cycle, all three outputs change at the next falling edge. The bench drives every input on a falling edge and samples on a later falling edge. It counts `busy` samples to measure the cycle length and compares a bench memory model with a shadow page computed from the start column, byte count and data formula. It sweeps every start column against byte counts from 1 to 10.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_BUSY = 1'b1
  } seq_state_e;
endpackage

// File: rtl/pw_page_buffer.sv
module pw_page_buffer #(
  parameter int ADDR_W     = 8,
  parameter int PAGE_BYTES = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    addr_set,
  input  logic [ADDR_W-1:0]       addr_in,
  input  logic                    wr_en,
  input  logic [7:0]              wr_data,
  input  logic [$clog2(PAGE_BYTES)-1:0] rd_idx,
  output logic [7:0]              rd_data,
  output logic                    rd_filled,
  output logic                    any_filled,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] upper
);
  localparam int COL_W = $clog2(PAGE_BYTES);
  localparam int UP_W  = ADDR_W - COL_W;

  logic [7:0]            slot_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] fill_q;
  logic [COL_W-1:0]      col_q;
  logic [UP_W-1:0]       upper_q;

  // column and fixed page bits; the column wraps by its own width
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q   <= '0;
      upper_q <= '0;
    end else if (addr_set) begin
      col_q   <= addr_in[COL_W-1:0];
      upper_q <= addr_in[ADDR_W-1:COL_W];
    end else if (wr_en) begin
      col_q   <= col_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) slot_q[i] <= '0;
    end else if (clear) begin
      fill_q <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (col_q == COL_W'(i)) begin
          slot_q[i] <= wr_data;
          fill_q[i] <= 1'b1;
        end
      end
    end
  end

  assign rd_data    = slot_q[rd_idx];
  assign rd_filled  = fill_q[rd_idx];
  assign any_filled = |fill_q;
  assign upper      = upper_q;
endmodule

// File: rtl/pw_wp_guard.sv
module pw_wp_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_start,
  input  logic d0_edge,
  input  logic wp,
  output logic cancel
);
  logic window_q;
  logic cancel_q;

  // the window opens at the D0 sampling edge and stays open until the next command
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      window_q <= 1'b0;
      cancel_q <= 1'b0;
    end else if (cmd_start) begin
      window_q <= 1'b0;
      cancel_q <= 1'b0;
    end else begin
      if (d0_edge) window_q <= 1'b1;
      if ((d0_edge || window_q) && wp) cancel_q <= 1'b1;
    end
  end

  assign cancel = cancel_q;
endmodule

// File: rtl/pw_write_seq.sv
module pw_write_seq
  import pw_pkg::*;
#(
  parameter int PAGE_BYTES = 8,
  parameter int WR_CYCLES  = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  wp,
  input  logic                  slot_filled,
  input  logic                  mem_ready,
  output logic [$clog2(PAGE_BYTES)-1:0] rd_idx,
  output logic                  mem_valid,
  output logic                  busy,
  output logic                  finish,
  output logic                  done,
  output logic                  aborted
);
  localparam int COL_W = $clog2(PAGE_BYTES);
  localparam int IDX_W = COL_W + 1;
  localparam int TMR_W = $clog2(WR_CYCLES + 1);

  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic [TMR_W-1:0] tmr_q;
  logic             walk_done;
  logic             expired;
  logic             step;

  assign walk_done = (idx_q == IDX_W'(PAGE_BYTES));
  assign expired   = (tmr_q == TMR_W'(WR_CYCLES - 1));
  assign busy      = (state_q == SEQ_BUSY);
  assign mem_valid = busy && !walk_done && slot_filled;
  assign step      = !walk_done && (!slot_filled || mem_ready);
  assign finish    = busy && (wp || (expired && walk_done));
  assign rd_idx    = idx_q[COL_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      tmr_q   <= '0;
      done    <= 1'b0;
      aborted <= 1'b0;
    end else begin
      done    <= 1'b0;
      aborted <= 1'b0;
      unique case (state_q)
        SEQ_IDLE: begin
          if (start) begin
            state_q <= SEQ_BUSY;
            idx_q   <= '0;
            tmr_q   <= '0;
          end
        end
        SEQ_BUSY: begin
          if (wp) begin
            state_q <= SEQ_IDLE;
            done    <= 1'b1;
            aborted <= 1'b1;
          end else begin
            if (step) idx_q <= idx_q + 1'b1;
            if (!expired) tmr_q <= tmr_q + 1'b1;
            if (expired && walk_done) begin
              state_q <= SEQ_IDLE;
              done    <= 1'b1;
            end
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/page_write_ctrl.sv
module page_write_ctrl #(
  parameter int ADDR_W     = 8,
  parameter int PAGE_BYTES = 8,
  parameter int WR_CYCLES  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              addr_set,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              d0_edge,
  input  logic              byte_valid,
  output logic              byte_ready,
  input  logic [7:0]        byte_data,
  input  logic              bit_pending,
  input  logic              stop_evt,
  input  logic              wp,
  output logic              busy,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [7:0]        mem_wr_data,
  output logic              cycle_done,
  output logic              cycle_aborted
);
  localparam int COL_W = $clog2(PAGE_BYTES);
  localparam int UP_W  = ADDR_W - COL_W;

  logic             busy_w;
  logic             finish_w;
  logic             cancel_w;
  logic             any_filled_w;
  logic             rd_filled_w;
  logic [7:0]       rd_data_w;
  logic [COL_W-1:0] rd_idx_w;
  logic [UP_W-1:0]  upper_w;
  logic             start_ok;
  logic             cmd_ok;

  assign cmd_ok     = cmd_start && !busy_w;
  assign byte_ready = !busy_w;
  assign start_ok   = stop_evt && !busy_w && !bit_pending && any_filled_w
                      && !cancel_w && !cmd_start;

  pw_page_buffer #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES)
  ) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (cmd_ok || finish_w),
    .addr_set   (addr_set && !busy_w),
    .addr_in    (addr_in),
    .wr_en      (byte_valid && !busy_w),
    .wr_data    (byte_data),
    .rd_idx     (rd_idx_w),
    .rd_data    (rd_data_w),
    .rd_filled  (rd_filled_w),
    .any_filled (any_filled_w),
    .upper      (upper_w)
  );

  pw_wp_guard u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_start (cmd_ok),
    .d0_edge   (d0_edge && !busy_w),
    .wp        (wp),
    .cancel    (cancel_w)
  );

  pw_write_seq #(
    .PAGE_BYTES (PAGE_BYTES),
    .WR_CYCLES  (WR_CYCLES)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start_ok),
    .wp          (wp),
    .slot_filled (rd_filled_w),
    .mem_ready   (mem_wr_ready),
    .rd_idx      (rd_idx_w),
    .mem_valid   (mem_wr_valid),
    .busy        (busy_w),
    .finish      (finish_w),
    .done        (cycle_done),
    .aborted     (cycle_aborted)
  );

  assign busy        = busy_w;
  assign mem_wr_addr = {upper_w, rd_idx_w};
  assign mem_wr_data = rd_data_w;
endmodule

// File: rtl/page_write_ctrl_chk.sv
module page_write_ctrl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              wp,
  input logic              stop_evt,
  input logic              bit_pending,
  input logic              byte_ready,
  input logic              mem_wr_valid,
  input logic              mem_wr_ready,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [7:0]        mem_wr_data,
  input logic              cycle_done,
  input logic              cycle_aborted
);
  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready && !wp) |=>
      (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  // R5
  done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |-> ($past(busy) && !busy));

  // R5
  abort_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_aborted |-> cycle_done);

  // R9
  no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !byte_ready);

  // R8
  wp_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wp) |=> (!busy && cycle_done && cycle_aborted));

  // R4
  partial_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && stop_evt && bit_pending) |=> !busy);

  // R3
  write_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> busy);
endmodule

bind page_write_ctrl page_write_ctrl_chk #(.ADDR_W(ADDR_W)) u_pw_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .wp            (wp),
  .stop_evt      (stop_evt),
  .bit_pending   (bit_pending),
  .byte_ready    (byte_ready),
  .mem_wr_valid  (mem_wr_valid),
  .mem_wr_ready  (mem_wr_ready),
  .mem_wr_addr   (mem_wr_addr),
  .mem_wr_data   (mem_wr_data),
  .cycle_done    (cycle_done),
  .cycle_aborted (cycle_aborted)
);

// File: tb/page_write_ctrl_bench.sv
`timescale 1ns/1ps
module page_write_ctrl_bench;
  localparam int ADDR_W = 8;
  localparam int PAGE   = 8;
  localparam int WRC    = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 0, addr_set = 0, d0_edge = 0, byte_valid = 0;
  logic bit_pending = 0, stop_evt = 0, wp = 0, mem_wr_ready = 1;
  logic [ADDR_W-1:0] addr_in = '0;
  logic [7:0] byte_data = '0;
  logic byte_ready, busy, mem_wr_valid, cycle_done, cycle_aborted;
  logic [ADDR_W-1:0] mem_wr_addr;
  logic [7:0] mem_wr_data;

  always #5 clk = ~clk;

  page_write_ctrl #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE), .WR_CYCLES(WRC)) u_page_write_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .addr_set(addr_set), .addr_in(addr_in),
    .d0_edge(d0_edge), .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data),
    .bit_pending(bit_pending), .stop_evt(stop_evt), .wp(wp), .busy(busy),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .cycle_done(cycle_done), .cycle_aborted(cycle_aborted));

  // memory array model and write counters
  logic [7:0] mem [256];
  logic [7:0] expm [256];
  int wr_cnt, oob_cnt;
  logic cnt_clr = 0;
  logic [4:0] cur_upper = '0;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'hFF;
      wr_cnt <= 0; oob_cnt <= 0;
    end else if (cnt_clr) begin
      wr_cnt <= 0; oob_cnt <= 0;
    end else if (mem_wr_valid && mem_wr_ready) begin
      mem[mem_wr_addr] <= mem_wr_data;
      wr_cnt <= wr_cnt + 1;
      if (mem_wr_addr[7:3] != cur_upper) oob_cnt <= oob_cnt + 1;
    end
  end

  function automatic logic [7:0] dval(input int seed, input int i);
    return 8'(seed * 29 + i * 7 + 3);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic clr_counts();
    @(negedge clk) cnt_clr = 1;
    @(negedge clk) cnt_clr = 0;
  endtask

  // one write command; wp_pre is high from START to the address, wp_d0 is high on the D0 edge and first byte
  task automatic send_cmd(input logic [7:0] a, input int n, input int seed,
                          input bit wp_pre, input bit wp_d0);
    @(negedge clk) cmd_start = 1; wp = wp_pre;
    @(negedge clk) cmd_start = 0; addr_set = 1; addr_in = a;
    @(negedge clk) addr_set = 0; wp = 0;
    if (n > 0) begin
      d0_edge = 1; wp = wp_d0;
      @(negedge clk) d0_edge = 0;
      for (int i = 0; i < n; i++) begin
        byte_valid = 1; byte_data = dval(seed, i);
        @(negedge clk);
        wp = 0;
      end
      byte_valid = 0;
    end
  endtask

  task automatic stop_pulse(input bit partial);
    stop_evt = 1; bit_pending = partial;
    @(negedge clk) stop_evt = 0; bit_pending = 0;
  endtask

  // counts busy samples from the first falling edge after STOP
  task automatic wait_idle(output int blen);
    blen = 0;
    while (busy === 1'b1 && blen < 5000) begin
      blen++;
      @(negedge clk);
    end
  endtask

  task automatic page_cmp(input logic [4:0] up, input string req);
    int bad = -1;
    for (int p = 0; p < PAGE; p++)
      if (bad < 0 && mem[{up, 3'(p)}] !== expm[{up, 3'(p)}]) bad = p;
    if (bad < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, req, mem[{up, 3'(bad)}], expm[{up, 3'(bad)}]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int blen, cnt_at;
    for (int i = 0; i < 256; i++) expm[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk(busy == 0 && mem_wr_valid == 0 && byte_ready == 1 && cycle_done == 0,
        "R5 reset", {busy, mem_wr_valid, byte_ready, cycle_done}, 4'b0010);

    // R4: partial byte at STOP
    cur_upper = 5'd2; clr_counts();
    send_cmd(8'h10, 3, 90, 0, 0);
    stop_pulse(1);
    chk(busy == 0, "R4 partial busy", busy, 0);
    repeat (5) @(negedge clk);
    chk(busy == 0 && wr_cnt == 0, "R4 partial no write", wr_cnt, 0);
    // R4: address only, no data byte
    send_cmd(8'h10, 0, 91, 0, 0);
    stop_pulse(0);
    chk(busy == 0, "R4 no data busy", busy, 0);
    repeat (3) @(negedge clk);
    chk(wr_cnt == 0, "R4 no data write", wr_cnt, 0);

    // R6: WP high at the D0 edge
    cur_upper = 5'd4; clr_counts();
    send_cmd(8'h20, 4, 92, 0, 1);
    stop_pulse(0);
    chk(busy == 0, "R6 cancel busy", busy, 0);
    repeat (3) @(negedge clk);
    chk(wr_cnt == 0, "R6 cancel write", wr_cnt, 0);
    page_cmp(5'd4, "R6 page unchanged");

    // R7: WP high only before the D0 edge
    cur_upper = 5'd5; clr_counts();
    send_cmd(8'h28, 4, 93, 1, 0);
    for (int i = 0; i < 4; i++) expm[8'h28 + i] = dval(93, i);
    stop_pulse(0);
    wait_idle(blen);
    chk(blen == WRC, "R7 cycle length", blen, WRC);
    chk(wr_cnt == 4, "R7 write count", wr_cnt, 4);
    page_cmp(5'd5, "R7 page data");

    // sweep: every start column against 1..10 bytes
    for (int col = 0; col < PAGE; col++) begin
      for (int n = 1; n <= 10; n++) begin
        logic [4:0] up;
        int seed;
        up = 5'((col * 3 + n) % 32);
        seed = col * 16 + n;
        cur_upper = up; clr_counts();
        send_cmd({up, 3'(col)}, n, seed, 0, 0);
        for (int i = 0; i < n; i++) expm[{up, 3'((col + i) % PAGE)}] = dval(seed, i);
        stop_pulse(0);
        wait_idle(blen);
        chk(blen == WRC, "R5 busy length", blen, WRC);
        chk(cycle_done == 1 && cycle_aborted == 0, "R5 done pulse",
            {cycle_done, cycle_aborted}, 2'b10);
        chk(wr_cnt == ((n > PAGE) ? PAGE : n), "R3 write count", wr_cnt, (n > PAGE) ? PAGE : n);
        chk(oob_cnt == 0, "R1 upper bits fixed", oob_cnt, 0);
        page_cmp(up, (n > PAGE) ? "R2 overwrite data" : "R1 wrap data");
      end
    end

    // R9 and R10: memory stalled, bytes offered while busy
    cur_upper = 5'd16; clr_counts();
    mem_wr_ready = 0;
    send_cmd(8'h80, 8, 200, 0, 0);
    for (int i = 0; i < 8; i++) expm[8'h80 + i] = dval(200, i);
    stop_pulse(0);
    chk(busy == 1, "R5 busy rise", busy, 1);
    byte_valid = 1; byte_data = 8'h5A;
    chk(byte_ready == 0, "R9 not ready", byte_ready, 0);
    @(negedge clk) byte_valid = 0;
    repeat (30) @(negedge clk);
    chk(busy == 1, "R10 busy stretched", busy, 1);
    chk(mem_wr_valid == 1 && mem_wr_addr == 8'h80 && mem_wr_data == dval(200, 0),
        "R10 request held", mem_wr_data, dval(200, 0));
    mem_wr_ready = 1;
    wait_idle(blen);
    chk(wr_cnt == 8, "R10 all written", wr_cnt, 8);
    page_cmp(5'd16, "R9 busy byte ignored");

    // R8: WP during the cycle
    cur_upper = 5'd30; clr_counts();
    send_cmd(8'hF0, 4, 201, 0, 0);
    stop_pulse(0);
    repeat (3) @(negedge clk);
    chk(busy == 1, "R8 busy before abort", busy, 1);
    wp = 1;
    @(negedge clk) wp = 0;
    chk(busy == 0 && cycle_done == 1 && cycle_aborted == 1, "R8 abort outputs",
        {busy, cycle_done, cycle_aborted}, 3'b011);
    cnt_at = wr_cnt;
    repeat (30) @(negedge clk);
    chk(wr_cnt == cnt_at && busy == 0, "R8 no write after abort", wr_cnt, cnt_at);

    finished = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule